// File: doc/BRIEF.md
# Sequential Prime Sieve Engine

This block produces prime numbers one at a time, in ascending order, using the sieve of Eratosthenes. It does the work serially rather than as unrolled logic. A controlling state machine owns a flag memory with one bit per integer below a parameterised limit. A set bit means the integer has been struck out as composite. Each found prime strikes its own multiples, and then the machine parks until another prime is wanted.

A slow external request strobe, typically one pulse per second, asks for the next prime. The engine latches the prime into a binary output register and raises a one-cycle valid pulse. It then converts the value into packed decimal digits for a display driver, using an iterative shift-and-add-3 converter. Requests that arrive while the engine is clearing memory or searching are counted and served in turn. Once the candidate range is used up, the engine reports completion and stops answering requests.

Because only one flag entry is touched per clock, the area grows with the flag memory and not with the size of the numbers.

Top module: `prime_sieve_engine`

## Requirements
- R1: While reset is asserted, `prime_o`, `digits_o`, `prime_valid_o`, `digits_valid_o` and `done_o` are all zero. After release, the engine spends LIMIT cycles clearing every flag entry, one per clock, before it does any search. A request that arrives during clearing is still served, and it yields the prime 2.
- R2: Each served request produces exactly one `prime_valid_o` pulse lasting one cycle. Over successive pulses, `prime_o` takes the primes below LIMIT in strictly increasing order starting at 2, with none skipped.
- R3: Between pulses, `prime_o` holds the most recently found prime.
- R4: A request that arrives while the engine is busy is counted in a pending counter. The counter saturates at 2^REQ_W-1. Every counted request is later served by its own pulse, and this holds even when a request lands in the same cycle that a search begins.
- R5: After prime p is found, the engine strikes p*p, p*p+p, p*p+2p and so on, while each value is below LIMIT. The next address comes from adding p, so no multiplier is used per step. Every flag write addresses an entry below LIMIT.
- R6: The search examines exactly one candidate per clock, and the candidate advances by one each time.
- R7: When the search reaches LIMIT without finding a clear flag, `done_o` goes high and stays high until reset. After that, `prime_o` keeps the last prime, and later requests produce no pulse on either valid output.
- R8: `digits_o` holds the value of the latched prime as D four-bit BCD digits, with digit 0 (the units) in bits [3:0] and each digit at most 9. `digits_valid_o` pulses for one cycle exactly W clocks after the `prime_valid_o` pulse for that prime, where W = clog2(LIMIT+1). A newer prime that arrives earlier restarts the conversion.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick_i | input | 1 | One-cycle request for the next prime |
| prime_o | output | W | Latest prime, binary |
| prime_valid_o | output | 1 | One-cycle pulse when a new prime is latched |
| digits_o | output | 4*D | Latest prime as BCD, units digit in bits [3:0] |
| digits_valid_o | output | 1 | One-cycle pulse when `digits_o` is updated |
| done_o | output | 1 | Candidate range exhausted (sticky until reset) |

## Verification
The two functions that can collide are request counting and search launch. A new request can arrive in exactly the clock edge where the idle state takes an older pending request and decrements the counter. The bench provokes this with request bursts on consecutive cycles and with requests spaced three cycles apart, so that several of them land on search starts. Correctness is judged by counting pulses against requests and by checking that every pulse carries the next prime that the bench computes by trial division.

// File: rtl/psieve_pkg.sv
package psieve_pkg;

  typedef enum logic [2:0] {
    S_CLEAR  = 3'd0,
    S_IDLE   = 3'd1,
    S_SCAN   = 3'd2,
    S_STRIKE = 3'd3,
    S_DONE   = 3'd4
  } sieve_state_t;

  // number of decimal digits needed to print v
  function automatic int dec_digits(input int v);
    int n;
    int r;
    n = 1;
    r = v;
    while (r >= 10) begin
      r = r / 10;
      n = n + 1;
    end
    return n;
  endfunction

endpackage

// File: rtl/psieve_flags.sv
module psieve_flags #(
  parameter int DEPTH = 1024,
  localparam int AIW = $clog2(DEPTH + 1),
  localparam int AW  = $clog2(DEPTH)
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           wr_en,
  input  logic [AIW-1:0] wr_addr,
  input  logic           wr_data,
  input  logic [AIW-1:0] rd_addr,
  output logic           rd_data
);

  // contents are not reset: the controller walks every entry after reset
  logic mem_q [DEPTH];

  always_ff @(posedge clk) begin
    if (wr_en && (wr_addr < AIW'(DEPTH))) begin
      mem_q[wr_addr[AW-1:0]] <= wr_data;
    end
  end

  // out-of-range reads look struck so they are never taken as prime
  assign rd_data = (rd_addr < AIW'(DEPTH)) ? mem_q[rd_addr[AW-1:0]] : 1'b1;

  // R5: every write stays inside the table
  a_r5_write_in_range: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |-> (wr_addr < AIW'(DEPTH)));

endmodule

// File: rtl/psieve_bcd.sv
module psieve_bcd #(
  parameter int W = 11,
  parameter int D = 4,
  localparam int SW = 4 * D + W,
  localparam int CW = $clog2(W + 1)
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           start_i,
  input  logic [W-1:0]   bin_i,
  output logic [4*D-1:0] digits_o,
  output logic           valid_o
);

  logic [SW-1:0]  sh_q, sh_d, adj;
  logic [CW-1:0]  cnt_q, cnt_d;
  logic [4*D-1:0] dig_q, dig_d;
  logic           val_q, val_d;

  // add 3 to every digit of 5 or more before each shift
  generate
    for (genvar g = 0; g < D; g++) begin : g_adj
      logic [3:0] dg;
      assign dg = sh_q[W + 4*g +: 4];
      assign adj[W + 4*g +: 4] = (dg >= 4'd5) ? dg + 4'd3 : dg;
    end
  endgenerate
  assign adj[W-1:0] = sh_q[W-1:0];

  always_comb begin
    sh_d  = sh_q;
    cnt_d = cnt_q;
    dig_d = dig_q;
    val_d = 1'b0;
    if (start_i) begin
      sh_d  = {{(4*D){1'b0}}, bin_i};
      cnt_d = CW'(W);
    end else if (cnt_q != '0) begin
      sh_d  = adj << 1;
      cnt_d = cnt_q - 1'b1;
      if (cnt_q == CW'(1)) begin
        dig_d = sh_d[SW-1:W];
        val_d = 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sh_q  <= '0;
      cnt_q <= '0;
      dig_q <= '0;
      val_q <= 1'b0;
    end else begin
      sh_q  <= sh_d;
      cnt_q <= cnt_d;
      dig_q <= dig_d;
      val_q <= val_d;
    end
  end

  assign digits_o = dig_q;
  assign valid_o  = val_q;

  // R8: each published digit is a legal decimal digit
  generate
    for (genvar g = 0; g < D; g++) begin : g_chk
      a_r8_digit_range: assert property (@(posedge clk) disable iff (!rst_n)
        val_q |-> (dig_q[4*g +: 4] <= 4'd9));
    end
  endgenerate

  // R8: result pulse lasts one cycle
  a_r8_valid_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    val_q |=> !val_q);

endmodule

// File: rtl/prime_sieve_engine.sv
module prime_sieve_engine
  import psieve_pkg::*;
#(
  parameter int LIMIT = 1024,
  parameter int REQ_W = 8,
  localparam int W  = $clog2(LIMIT + 1),
  localparam int D  = dec_digits(LIMIT - 1),
  localparam int MW = 2 * W
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           tick_i,
  output logic [W-1:0]   prime_o,
  output logic           prime_valid_o,
  output logic [4*D-1:0] digits_o,
  output logic           digits_valid_o,
  output logic           done_o
);

  localparam logic [W-1:0]     LIM_W   = W'(LIMIT);
  localparam logic [MW-1:0]    LIM_M   = MW'(LIMIT);
  localparam logic [REQ_W-1:0] REQ_MAX = '1;

  sieve_state_t     state_q, state_d;
  logic [W-1:0]     cand_q, cand_d;
  logic [W-1:0]     clr_q, clr_d;
  logic [W-1:0]     prime_q, prime_d;
  logic [MW-1:0]    mult_q, mult_d;
  logic [REQ_W-1:0] req_q, req_d;
  logic             pval_q, pval_d;

  logic             flag_rd, wr_en, wr_data, found, launch, req_inc;
  logic [W-1:0]     wr_addr;
  logic [MW-1:0]    square;

  psieve_flags #(.DEPTH(LIMIT)) u_flags (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr_en   (wr_en),
    .wr_addr (wr_addr),
    .wr_data (wr_data),
    .rd_addr (cand_q),
    .rd_data (flag_rd)
  );

  assign square  = MW'(cand_q) * MW'(cand_q);
  assign found   = (state_q == S_SCAN) && (cand_q != LIM_W) && !flag_rd;
  assign launch  = (state_q == S_IDLE) && (req_q != '0);
  assign req_inc = tick_i && (state_q != S_DONE) && (req_q != REQ_MAX);

  // flag write port: clear walk or strike step
  always_comb begin
    wr_en   = 1'b0;
    wr_addr = clr_q;
    wr_data = 1'b0;
    if (state_q == S_CLEAR) begin
      wr_en = 1'b1;
    end else if ((state_q == S_STRIKE) && (mult_q < LIM_M)) begin
      wr_en   = 1'b1;
      wr_addr = mult_q[W-1:0];
      wr_data = 1'b1;
    end
  end

  // next-state logic
  always_comb begin
    state_d = state_q;
    cand_d  = cand_q;
    clr_d   = clr_q;
    prime_d = prime_q;
    mult_d  = mult_q;
    pval_d  = 1'b0;
    req_d   = req_q + REQ_W'(req_inc) - REQ_W'(launch);
    unique case (state_q)
      S_CLEAR: begin
        clr_d = clr_q + 1'b1;
        if (clr_q == W'(LIMIT - 1)) state_d = S_IDLE;
      end
      S_IDLE: begin
        if (launch) state_d = S_SCAN;
      end
      S_SCAN: begin
        if (cand_q == LIM_W) begin
          state_d = S_DONE;
        end else begin
          cand_d = cand_q + 1'b1;
          if (found) begin
            prime_d = cand_q;
            pval_d  = 1'b1;
            mult_d  = square;
            state_d = S_STRIKE;
          end
        end
      end
      S_STRIKE: begin
        if (mult_q < LIM_M) mult_d = mult_q + MW'(prime_q);
        else                state_d = S_IDLE;
      end
      S_DONE: state_d = S_DONE;
      default: state_d = S_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= S_CLEAR;
      cand_q  <= W'(2);
      clr_q   <= '0;
      prime_q <= '0;
      mult_q  <= '0;
      req_q   <= '0;
      pval_q  <= 1'b0;
    end else begin
      state_q <= state_d;
      cand_q  <= cand_d;
      clr_q   <= clr_d;
      prime_q <= prime_d;
      mult_q  <= mult_d;
      req_q   <= req_d;
      pval_q  <= pval_d;
    end
  end

  psieve_bcd #(.W(W), .D(D)) u_bcd (
    .clk      (clk),
    .rst_n    (rst_n),
    .start_i  (pval_d),
    .bin_i    (prime_d),
    .digits_o (digits_o),
    .valid_o  (digits_valid_o)
  );

  assign prime_o       = prime_q;
  assign prime_valid_o = pval_q;
  assign done_o        = (state_q == S_DONE);

  // R2: new-prime pulse lasts one cycle
  a_r2_valid_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    pval_q |=> !pval_q);
  // R2: a reported prime is inside the sieved range
  a_r2_prime_range: assert property (@(posedge clk) disable iff (!rst_n)
    pval_q |-> (prime_q >= W'(2)) && (prime_q < LIM_W));
  // R3: output holds between pulses
  a_r3_prime_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !pval_d |=> $stable(prime_q));
  // R6: a struck candidate advances by exactly one
  a_r6_scan_step: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == S_SCAN && cand_q != LIM_W && flag_rd) |=> (cand_q == $past(cand_q) + 1'b1));
  // R7: completion is sticky and freezes the prime
  a_r7_done_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |=> done_o && $stable(prime_q) && !pval_q);
  // R4: a counted request with no launch raises the pending count
  a_r4_req_count: assert property (@(posedge clk) disable iff (!rst_n)
    (req_inc && !launch) |=> (req_q == $past(req_q) + 1'b1));

endmodule

// File: tb/prime_sieve_engine_bench.sv
module prime_sieve_engine_bench;

  localparam int LIMIT = 128;
  localparam int W = 8;   // clog2(LIMIT+1)
  localparam int D = 3;   // digits of LIMIT-1

  logic           clk, rst_n, tick;
  logic [W-1:0]   prime;
  logic           pvalid, dvalid, done;
  logic [4*D-1:0] digits;

  int checks, fails, pulses, exp_last, cyc, last_pv_cyc;
  logic prev_pv;

  prime_sieve_engine #(.LIMIT(LIMIT)) u_prime_sieve_engine (
    .clk(clk), .rst_n(rst_n), .tick_i(tick),
    .prime_o(prime), .prime_valid_o(pvalid),
    .digits_o(digits), .digits_valid_o(dvalid), .done_o(done)
  );

  initial clk = 1'b0;
  always #2.5 clk = ~clk;

  function automatic bit is_prime(input int v);
    if (v < 2) return 1'b0;
    for (int k = 2; k * k <= v; k++) if (v % k == 0) return 1'b0;
    return 1'b1;
  endfunction

  function automatic int next_prime(input int v);
    int n;
    n = v + 1;
    while (!is_prime(n)) n++;
    return n;
  endfunction

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic pulse_tick();
    @(negedge clk) tick = 1'b1;
    @(negedge clk) tick = 1'b0;
  endtask

  task automatic wait_pulses(input int n);
    int t;
    t = 0;
    while (pulses < n && t < 5000) begin
      @(negedge clk);
      t++;
    end
    check(pulses == n, "R4 pulse count", pulses, n);
  endtask

  task automatic do_reset();
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    check(prime == 0 && !pvalid && !dvalid && !done && digits == 0,
          "R1 reset state", int'(prime), 0);
    rst_n = 1'b1;
    pulses = 0;
    exp_last = 0;
  endtask

  // output monitor
  always @(negedge clk) begin
    cyc++;
    if (rst_n) begin
      if (pvalid) begin
        check(!prev_pv, "R2 single-cycle pulse", 1, 0);
        check(!done, "R7 pulse after done", 1, 0);
        check(int'(prime) == next_prime(exp_last), "R2 R5 R6 next prime",
              int'(prime), next_prime(exp_last));
        exp_last = next_prime(exp_last);
        pulses++;
        last_pv_cyc = cyc;
      end
      if (dvalid) begin
        int v;
        v = 0;
        for (int i = D - 1; i >= 0; i--) v = v * 10 + int'(digits[4*i +: 4]);
        check(v == int'(prime), "R8 digits value", v, int'(prime));
        check(cyc - last_pv_cyc == W, "R8 digits latency", cyc - last_pv_cyc, W);
      end
      prev_pv = pvalid;
    end else begin
      prev_pv = 1'b0;
    end
  end

  // watchdog
  initial begin
    repeat (150000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired actual=%0d expected=%0d", 150000, 0);
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    checks = 0; fails = 0; cyc = 0; last_pv_cyc = 0; prev_pv = 1'b0;
    tick = 1'b0;
    do_reset();

    // R1: request during the clear walk is held and answered with 2
    repeat (10) @(negedge clk);
    pulse_tick();
    repeat (LIMIT - 20) @(negedge clk);
    check(pulses == 0, "R1 no result while clearing", pulses, 0);
    wait_pulses(1);
    check(int'(prime) == 2, "R1 first prime", int'(prime), 2);

    // spaced requests
    for (int i = 0; i < 10; i++) begin
      pulse_tick();
      wait_pulses(2 + i);
      repeat (20) @(negedge clk);
      check(int'(prime) == exp_last, "R3 hold between pulses", int'(prime), exp_last);
    end

    // R4: burst on consecutive cycles while busy
    @(negedge clk) tick = 1'b1;
    repeat (5) @(negedge clk);
    tick = 1'b0;
    wait_pulses(16);

    // R4: requests every third cycle, colliding with search launches
    for (int i = 0; i < 15; i++) begin
      @(negedge clk) tick = 1'b1;
      @(negedge clk) tick = 1'b0;
      @(negedge clk);
    end
    wait_pulses(31);
    check(int'(prime) == 127, "R2 last prime", int'(prime), 127);
    check(!done, "R7 not done yet", int'(done), 0);

    // R7: exhaust the range
    pulse_tick();
    repeat (20) @(negedge clk);
    check(done, "R7 done raised", int'(done), 1);
    check(int'(prime) == 127, "R7 last prime held", int'(prime), 127);

    // R7: later requests are ignored
    for (int i = 0; i < 3; i++) pulse_tick();
    repeat (60) @(negedge clk);
    check(pulses == 31, "R7 ignored requests", pulses, 31);
    check(done && int'(prime) == 127, "R7 state after ignored requests", int'(prime), 127);

    // reset restarts the sequence
    do_reset();
    pulse_tick();
    wait_pulses(1);
    check(int'(prime) == 2, "R1 restart from 2", int'(prime), 2);
    repeat (20) @(negedge clk);

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

endmodule